// File: doc/BRIEF.md
# Time-Triggered Compare Match Unit

This block sits next to a time-triggered CAN controller and turns timer coincidences into interrupt flags and control pulses. It holds three 16-bit compare values. Channel 0 watches the free-running local time counter, and channels 1 and 2 watch the cycle time counter. When a channel's counter first becomes equal to its compare value, that channel raises a flag in a 16-bit interrupt request word. It raises the flag only if the channel's enable bit in control word 0 is set. The flag is mirrored into a 4-bit timer status word. An interrupt output is driven from every request bit that is not masked.

Two channels also have side effects. A channel 0 match sends a one-cycle clear pulse to the local timer. In time-triggered mode a control bit can suppress that pulse. A channel 2 match sends a one-cycle pulse that flushes the transmit queue. The block also keeps a reference mark. At start-of-frame of a reference message it holds the local time as a pending value. It commits that value only when the message completes successfully. In event-triggered mode the mark reads zero.

Top module: `ttcm_unit`

## Requirements
- R1: Channel 0 compares `cmp0` with `local_time`. Channels 1 and 2 compare `cmp1` and `cmp2` with `cycle_time`. A match exists only in the cycle in which equality first appears, so a counter that stays equal gives one match. The resulting flag is visible after the next rising clock edge.
- R2: A match on channel 0, 1 or 2 sets its flag only when `ctrl0` bit 12, 11 or 10 respectively is 1.
- R3: The flags of channels 0, 1 and 2 appear at `irq_req` bits 11, 15 and 14. Every other bit of `irq_req` reads 0.
- R4: When a flag is set, `tstat` bit 3, 2 or 1 (channel 0, 1, 2) is set in the same cycle. Clearing the flag clears that status bit. `tstat` bit 0 reads 0.
- R5: Writing a 1 to a bit of `irq_clr` for one cycle clears the matching request bit. A match that sets the bit in the same cycle wins, and the bit stays set.
- R6: `irq_out` is 1 exactly when some bit of `irq_req` is 1 and the same bit of `irq_mask` is 0.
- R7: A channel 0 match produces a one-cycle `ltimer_clr` pulse after the next edge, whatever the enable bits are. When `tt_mode` is 1 and `ctrl0` bit 6 is 0, the pulse is suppressed.
- R8: A channel 2 match produces a one-cycle `txq_flush` pulse after the next edge. Channels 0 and 1 never produce it.
- R9: `sof_ref` captures `local_time` into a pending value. `msg_ok` copies the pending value into `ref_mark`. `msg_err` discards it, so a later `msg_ok` leaves `ref_mark` unchanged. `ref_mark` resets to 0.
- R10: While `tt_mode` is 0, `ref_mark` reads 0, its stored value is cleared and no commit takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tt_mode | input | 1 | 1 = time-triggered, 0 = event-triggered |
| ctrl0 | input | 16 | Control word 0: bits 12/11/10 are the flag enables, bit 6 enables the local-timer clear |
| irq_mask | input | 16 | Interrupt mask, 1 = masked (bits 11/15/14) |
| irq_clr | input | 16 | Write-1-to-clear strobe for `irq_req` |
| cmp0 | input | 16 | Compare value for channel 0 (local time) |
| cmp1 | input | 16 | Compare value for channel 1 (cycle time) |
| cmp2 | input | 16 | Compare value for channel 2 (cycle time) |
| local_time | input | 16 | Local time counter value |
| cycle_time | input | 16 | Cycle time counter value |
| sof_ref | input | 1 | Start-of-frame strobe of a reference message |
| msg_ok | input | 1 | Reference message completed successfully |
| msg_err | input | 1 | Reference message aborted with an error |
| irq_req | output | 16 | Interrupt request word |
| tstat | output | 4 | Timer status word |
| irq_out | output | 1 | OR of the unmasked request bits |
| ltimer_clr | output | 1 | One-cycle local-timer clear pulse |
| txq_flush | output | 1 | One-cycle transmit-queue flush pulse |
| ref_mark | output | 16 | Captured reference mark |

## Verification
The main pattern is a sweep over all eight enable combinations crossed with all eight mask combinations. In each step every channel is fired at once. This separates the routing of each enable to its own flag bit, status bit and mask bit, and a swapped bit position shows up as a mismatch.

Targeted patterns cover the other cases:
- A counter held at the compare value, which distinguishes an edge match from a level match.
- A clear arriving together with a new match, which checks that the set wins.
- A clear of a single bit next to other set bits.
- The local counter passing the cycle compare values and the reverse, which checks that each channel uses its own time base.
- Commits after an error, and commits in event-triggered mode.

// File: rtl/ttcm_pkg.sv
// Shared constants for the compare match unit: channel count and the
// register bit positions that software and neighbouring logic decode.
package ttcm_pkg;
    localparam int NUM_CH      = 3;
    localparam int TIME_W      = 16;
    localparam int REG_W       = 16;
    localparam int STS_W       = 4;
    localparam int LTCLR_EN_POS = 6;

    // Flag-enable bit in control word 0 for a channel.
    function automatic int en_pos(input int ch);
        return 12 - ch;
    endfunction

    // Interrupt request / mask bit for a channel.
    function automatic int irq_pos(input int ch);
        case (ch)
            0:       return 11;
            1:       return 15;
            default: return 14;
        endcase
    endfunction

    // Timer status bit for a channel.
    function automatic int sts_pos(input int ch);
        return 3 - ch;
    endfunction
endpackage

// File: rtl/ttcm_edge_cmp.sv
// Edge compare: reports a hit only in the cycle where the counter first
// equals the compare value. Assumes both inputs are synchronous to clk.
module ttcm_edge_cmp #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] count,
    input  logic [TW-1:0] cmp_val,
    output logic          hit
);
    logic eq_now;
    logic eq_q;

    assign eq_now = (count == cmp_val);
    assign hit    = eq_now & ~eq_q;

    // Remember last cycle's equality so a held match fires once.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq_now;
    end

    assert_single_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/ttcm_flag_cell.sv
// One interrupt request flag and its status mirror. Set has priority
// over a write-1 clear arriving in the same cycle.
module ttcm_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o,
    output logic sts_o
);
    // Request flag: set wins, else clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // Status mirror: follows the same set and the linked clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     sts_o <= 1'b0;
        else if (set_i) sts_o <= 1'b1;
        else if (clr_i) sts_o <= 1'b0;
    end

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_clear_links_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> (!flag_o && !sts_o));
    assert_status_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o == sts_o);
endmodule

// File: rtl/ttcm_refmark.sv
// Reference mark capture: start-of-frame loads a pending copy of local
// time, a success strobe commits it, an error drops it. Held at zero
// outside time-triggered mode.
module ttcm_refmark #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tt_mode,
    input  logic [TW-1:0] local_time,
    input  logic          sof_ref,
    input  logic          msg_ok,
    input  logic          msg_err,
    output logic [TW-1:0] mark
);
    logic [TW-1:0] pend_q;
    logic          pend_v;
    logic [TW-1:0] mark_q;
    logic          commit;

    assign commit = tt_mode & msg_ok & ~msg_err & pend_v;

    // Pending capture: a new start-of-frame replaces, an end strobe retires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            pend_v <= 1'b0;
        end else if (sof_ref) begin
            pend_q <= local_time;
            pend_v <= 1'b1;
        end else if (msg_ok || msg_err) begin
            pend_v <= 1'b0;
        end
    end

    // Committed mark: cleared in event-triggered mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       mark_q <= '0;
        else if (!tt_mode) mark_q <= '0;
        else if (commit)  mark_q <= pend_q;
    end

    assign mark = tt_mode ? mark_q : '0;

    assert_err_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_err && !sof_ref) |=> !pend_v);
    assert_commit_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (mark_q == $past(pend_q)));
    assert_et_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tt_mode |=> (mark_q == '0));
endmodule

// File: rtl/ttcm_unit.sv
// Compare match unit top: three edge compares on two time bases,
// enable-gated request flags with status mirrors, a masked interrupt,
// local-timer clear and transmit-flush pulses, and the reference mark.
// Assumes all inputs are synchronous to clk; strobes are one cycle wide.
module ttcm_unit
    import ttcm_pkg::*;
#(
    parameter int TW = TIME_W,
    parameter int RW = REG_W,
    parameter int SW = STS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tt_mode,
    input  logic [RW-1:0] ctrl0,
    input  logic [RW-1:0] irq_mask,
    input  logic [RW-1:0] irq_clr,
    input  logic [TW-1:0] cmp0,
    input  logic [TW-1:0] cmp1,
    input  logic [TW-1:0] cmp2,
    input  logic [TW-1:0] local_time,
    input  logic [TW-1:0] cycle_time,
    input  logic          sof_ref,
    input  logic          msg_ok,
    input  logic          msg_err,
    output logic [RW-1:0] irq_req,
    output logic [SW-1:0] tstat,
    output logic          irq_out,
    output logic          ltimer_clr,
    output logic          txq_flush,
    output logic [TW-1:0] ref_mark
);
    localparam int NCH = NUM_CH;

    logic [TW-1:0]  cmp_arr [NCH];
    logic [NCH-1:0] hit;
    logic [NCH-1:0] flag_v;
    logic [NCH-1:0] sts_v;
    logic           unused_ctrl;

    assign cmp_arr[0] = cmp0;
    assign cmp_arr[1] = cmp1;
    assign cmp_arr[2] = cmp2;

    // Per-channel compare and flag; channel 0 uses local time.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [TW-1:0] base;
        assign base = (c == 0) ? local_time : cycle_time;

        ttcm_edge_cmp #(.TW(TW)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .count   (base),
            .cmp_val (cmp_arr[c]),
            .hit     (hit[c])
        );

        ttcm_flag_cell u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (hit[c] & ctrl0[en_pos(c)]),
            .clr_i  (irq_clr[irq_pos(c)]),
            .flag_o (flag_v[c]),
            .sts_o  (sts_v[c])
        );
    end

    // Place channel flags and status at their register bit positions.
    always_comb begin
        irq_req = '0;
        tstat   = '0;
        for (int c = 0; c < NCH; c++) begin
            irq_req[irq_pos(c)] = flag_v[c];
            tstat[sts_pos(c)]   = sts_v[c];
        end
    end

    assign irq_out = |(irq_req & ~irq_mask);

    // Side-effect pulses, one cycle after the match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ltimer_clr <= 1'b0;
            txq_flush  <= 1'b0;
        end else begin
            ltimer_clr <= hit[0] & (~tt_mode | ctrl0[LTCLR_EN_POS]);
            txq_flush  <= hit[NCH-1];
        end
    end

    ttcm_refmark #(.TW(TW)) u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .tt_mode    (tt_mode),
        .local_time (local_time),
        .sof_ref    (sof_ref),
        .msg_ok     (msg_ok),
        .msg_err    (msg_err),
        .mark       (ref_mark)
    );

    assign unused_ctrl = ^{ctrl0, irq_clr};

    assert_ltclr_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tt_mode && !ctrl0[LTCLR_EN_POS]) |=> !ltimer_clr);
    assert_ltclr_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ltimer_clr |-> $past(hit[0]));
    assert_flush_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit[NCH-1] |=> txq_flush);
    assert_enable_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl0[en_pos(0)] && !flag_v[0]) |=> !flag_v[0]);
endmodule

// File: tb/tb_ttcm_unit.sv
module tb_ttcm_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tt_mode;
    logic [15:0] ctrl0, irq_mask, irq_clr, cmp0, cmp1, cmp2, local_time, cycle_time;
    logic        sof_ref, msg_ok, msg_err;
    logic [15:0] irq_req, ref_mark;
    logic [3:0]  tstat;
    logic        irq_out, ltimer_clr, txq_flush;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    ttcm_unit dut (
        .clk(clk), .rst_n(rst_n), .tt_mode(tt_mode), .ctrl0(ctrl0),
        .irq_mask(irq_mask), .irq_clr(irq_clr), .cmp0(cmp0), .cmp1(cmp1),
        .cmp2(cmp2), .local_time(local_time), .cycle_time(cycle_time),
        .sof_ref(sof_ref), .msg_ok(msg_ok), .msg_err(msg_err),
        .irq_req(irq_req), .tstat(tstat), .irq_out(irq_out),
        .ltimer_clr(ltimer_clr), .txq_flush(txq_flush), .ref_mark(ref_mark)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        local_time = 0; cycle_time = 0; irq_clr = 16'hFFFF;
        step();
        irq_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; tt_mode = 1; ctrl0 = 16'h1C40; irq_mask = 0; irq_clr = 0;
        cmp0 = 100; cmp1 = 200; cmp2 = 200; local_time = 0; cycle_time = 0;
        sof_ref = 0; msg_ok = 0; msg_err = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R3 reset irq_req", irq_req, 0);
        chk("R4 reset tstat", tstat, 0);
        chk("R6 reset irq_out", irq_out, 0);
        chk("R9 reset ref_mark", ref_mark, 0);

        // Sweep: all enable x mask combinations, all channels fired together.
        for (int e = 0; e < 8; e++) begin
            for (int m = 0; m < 8; m++) begin
                logic [15:0] ei, mk;
                logic [3:0]  es;
                ctrl0    = 16'h0040 | (16'(e & 1) << 12) | (16'((e >> 1) & 1) << 11)
                           | (16'((e >> 2) & 1) << 10);
                mk       = (16'(m & 1) << 11) | (16'((m >> 1) & 1) << 15)
                           | (16'((m >> 2) & 1) << 14);
                irq_mask = mk;
                ei = (16'(e & 1) << 11) | (16'((e >> 1) & 1) << 15) | (16'((e >> 2) & 1) << 14);
                es = (4'(e & 1) << 3) | (4'((e >> 1) & 1) << 2) | (4'((e >> 2) & 1) << 1);
                local_time = 100; cycle_time = 200;
                step();
                chk("R1 R2 R3 sweep irq_req", irq_req, ei);
                chk("R4 sweep tstat", tstat, es);
                chk("R6 sweep irq_out", irq_out, (ei & ~mk) != 0);
                chk("R7 sweep ltimer_clr", ltimer_clr, 1);
                chk("R8 sweep txq_flush", txq_flush, 1);
                clear_all();
                chk("R5 sweep cleared", irq_req, 0);
                chk("R4 sweep tstat cleared", tstat, 0);
                chk("R6 sweep irq_out low", irq_out, 0);
                chk("R7 pulse one cycle", ltimer_clr, 0);
                chk("R8 pulse one cycle", txq_flush, 0);
            end
        end
        irq_mask = 0; ctrl0 = 16'h1C40;

        // R1: held equal counter fires once.
        local_time = 100; step();
        chk("R1 held first hit", irq_req, 16'h0800);
        irq_clr = 16'h0800; step(); irq_clr = 0;
        chk("R1 held no refire", irq_req, 0);
        chk("R1 held no ltimer pulse", ltimer_clr, 0);
        step();
        chk("R1 held still clear", irq_req, 0);
        local_time = 0; step();

        // R5: set wins over same-cycle clear.
        local_time = 100; step();
        local_time = 0; step();
        local_time = 100; irq_clr = 16'h0800; step(); irq_clr = 0;
        chk("R5 set wins flag", irq_req, 16'h0800);
        chk("R4 set wins status", tstat, 4'h8);
        local_time = 0;
        cycle_time = 200; step(); cycle_time = 0;
        irq_clr = 16'h0800; step(); irq_clr = 0;
        chk("R5 single-bit clear", irq_req, 16'hC000);
        chk("R4 single-bit clear status", tstat, 4'h6);
        irq_mask = 16'hC000; step();
        chk("R6 all masked", irq_out, 0);
        irq_mask = 16'h4000; step();
        chk("R6 one unmasked", irq_out, 1);
        irq_mask = 0;
        clear_all();

        // R7: bit 6 low in time-triggered mode blocks the clear pulse.
        ctrl0 = 16'h1C00; local_time = 100; step();
        chk("R7 tt blocked pulse", ltimer_clr, 0);
        chk("R7 tt blocked flag still set", irq_req, 16'h0800);
        local_time = 0; tt_mode = 0; step();
        local_time = 100; step();
        chk("R7 et pulse", ltimer_clr, 1);
        tt_mode = 1; ctrl0 = 16'h1C40;
        clear_all();

        // R1: each channel uses its own time base.
        cycle_time = 100; step();
        chk("R1 ch0 ignores cycle_time", irq_req, 0);
        cycle_time = 0; local_time = 200; step();
        chk("R1 ch1/ch2 ignore local_time", irq_req, 0);
        chk("R8 no flush from local", txq_flush, 0);
        local_time = 0; step();

        // R8: flush only from channel 2.
        cmp2 = 300; cycle_time = 200; step();
        chk("R8 ch1 no flush", txq_flush, 0);
        cycle_time = 300; step();
        chk("R8 ch2 flush", txq_flush, 1);
        chk("R3 ch2 bit", irq_req, 16'hC000);
        cmp2 = 200;
        clear_all();

        // R9/R10: reference mark capture.
        local_time = 16'h1234; sof_ref = 1; step(); sof_ref = 0;
        chk("R9 pending not visible", ref_mark, 0);
        msg_ok = 1; step(); msg_ok = 0;
        chk("R9 commit", ref_mark, 16'h1234);
        local_time = 16'h2222; sof_ref = 1; step(); sof_ref = 0;
        msg_err = 1; step(); msg_err = 0;
        msg_ok = 1; step(); msg_ok = 0;
        chk("R9 error discards", ref_mark, 16'h1234);
        tt_mode = 0; step();
        chk("R10 et reads zero", ref_mark, 0);
        local_time = 16'h3333; sof_ref = 1; step(); sof_ref = 0;
        msg_ok = 1; step(); msg_ok = 0;
        chk("R10 et no commit", ref_mark, 0);
        tt_mode = 1; step();
        chk("R10 stored value cleared", ref_mark, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule